// File: doc/BRIEF.md
# SMBus Slave Control Register Interface

This block lets a host on a two-wire SMBus read and write a small bank of 8-bit control registers. The SCL and SDA lines are oversampled by the system clock. Start and stop conditions are recognised on those sampled lines. The slave answers only its own 7-bit address, and it pulls SDA low through an open-drain enable whenever it sends an acknowledge or a zero data bit.

The command byte that follows the address sets the kind of access:

- **Byte access.** A command with its top bit set names a single register through its low seven bits.
- **Block access.** A command of all zeros starts a block transfer at register 0.
  - A block write carries a count byte first.
  - A block read returns a count byte from the slave before the data.

All register contents are presented in parallel to the rest of the chip. One register holds a fixed identification value that writes cannot change. Another register has bits that always hold 1.

Top module: `smbr_slave`

## Requirements
- R1: Only an address byte whose upper seven bits equal SLAVE_ADDR (default 7'h69) is acknowledged. For any other address, SDA stays released until the next start condition, and no register changes.
- R2: A byte write is a sequence: address with R/W bit 0, then a command with bit 7 = 1, then one data byte. It stores the data at the register given by command bits 6:0, and all three bytes are acknowledged. A second data byte in the same transfer is not acknowledged.
- R3: A byte read is a sequence: address with write, a command with bit 7 = 1, a repeated start, then address with R/W bit 1. The slave returns the register at command bits 6:0. An offset at or beyond NUM_REGS reads as 8'hFF.
- R4: A block write is a sequence: address with write, command 8'h00, a count byte, then data bytes. Data byte k is stored in register k, counting from 0. Data bytes beyond the count, or beyond the last register, are not acknowledged and store nothing.
- R5: A block read is a sequence: command 8'h00, a repeated start, then address with read. The slave first returns a count byte equal to NUM_REGS, then registers 0, 1, 2 and onward until the master sends a NACK.
- R6: Register ID_IDX (default 6) always holds ID_VALUE (default 8'h29). Writes to it have no effect.
- R7: Register ONES_IDX (default 7) always has the bits of ONES_MASK (default 8'hC0) set, whatever value is written to it.
- R8: A stop condition at any point returns the block to idle with SDA released. A byte that is only partly shifted in at that moment stores nothing.
- R9: A command byte whose bit 7 is 0 and which is not 8'h00 is not acknowledged.
- R10: The slave never changes its SDA drive while SCL is high. Its drive changes only after a falling SCL edge.
- R11: After reset, every register reads 0, except the identification register and the forced-one bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Register contents; register k sits in bits 8k+7:8k |

## Verification
A stop condition and the shifting of a data bit are both decided while SCL is high, and they can meet inside the same byte. The bench provokes this by stopping a block write after only half of a data byte has been clocked in. It then checks that the registers are unchanged, that SDA is released, and that a following byte read works normally. A second overlap is a repeated start arriving while a command is still set up for writing. Each block and byte read exercises this, and the bench judges it by the count byte and the data bytes it reads back.

// File: rtl/smbr_pkg.sv
// Package: shared types for the SMBus register slave.
// Assumes: one transfer engine per slave; encodings are internal only.
package smbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // no transfer in progress
        ST_ADDR  = 3'd1,   // shifting the address byte
        ST_CMD   = 3'd2,   // shifting the command byte
        ST_WDATA = 3'd3,   // master is writing count or data
        ST_TX    = 3'd4,   // slave is returning bytes
        ST_SKIP  = 3'd5    // not addressed or refused: wait for start/stop
    } smbr_state_e;

    localparam logic [7:0] BLOCK_CODE = 8'h00;
endpackage

// File: rtl/smbr_line_sync.sv
// Module: smbr_line_sync
// Brings SCL/SDA into the clk domain and flags SCL edges plus start/stop.
// Assumes: bus lines change far slower than clk (several clk per SCL phase).
module smbr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sy;
    logic [STAGES-1:0] sda_sy;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains and one-cycle history; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[STAGES-2:0], sda_i};
            scl_q  <= scl_sy[STAGES-1];
            sda_q  <= sda_sy[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized lines.
    always_comb begin
        scl_o      = scl_sy[STAGES-1];
        sda_o      = sda_sy[STAGES-1];
        scl_rise_o = scl_o & ~scl_q;
        scl_fall_o = ~scl_o & scl_q;
        start_o    = scl_o & scl_q & sda_q & ~sda_o;
        stop_o     = scl_o & scl_q & ~sda_q & sda_o;
    end
endmodule

// File: rtl/smbr_regbank.sv
// Module: smbr_regbank
// Holds the control registers; one register is a fixed read-only ID,
// another keeps a set of bits forced to one.
// Assumes: at most one write per cycle; ID_IDX and ONES_IDX < NUM_REGS.
module smbr_regbank #(
    parameter int         NUM_REGS  = 8,
    parameter int         IDX_W     = 7,
    parameter int         ID_IDX    = 6,
    parameter logic [7:0] ID_VALUE  = 8'h29,
    parameter int         ONES_IDX  = 7,
    parameter logic [7:0] ONES_MASK = 8'hC0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = (g == ID_IDX)   ? ID_VALUE :
                                         (g == ONES_IDX) ? ONES_MASK : 8'h00;
        localparam logic [7:0] FORCE   = (g == ONES_IDX) ? ONES_MASK : 8'h00;
        localparam bit         LOCKED  = (g == ID_IDX);
        logic [7:0] r;

        // Storage for one register; locked register ignores writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= RST_VAL;
            else if (wr_en && wr_idx == IDX_W'(g) && !LOCKED)
                r <= wr_data | FORCE;
        end
        assign regs_o[g*8 +: 8] = r;

        if (LOCKED) begin : g_id_chk
            // R6
            id_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(g)) |=> $stable(r));
        end
        if (FORCE != 8'h00) begin : g_ones_chk
            // R7
            ones_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> ((r & FORCE) == FORCE));
        end
    end
endmodule

// File: rtl/smbr_slave.sv
// Module: smbr_slave (top)
// SMBus slave giving byte and block access to a control register bank.
// Assumes: SCL phases last several clk cycles; no clock stretching, no PEC.
module smbr_slave #(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter int         ID_IDX      = 6,
    parameter logic [7:0] ID_VALUE    = 8'h29,
    parameter int         ONES_IDX    = 7,
    parameter logic [7:0] ONES_MASK   = 8'hC0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    import smbr_pkg::*;

    localparam int         PTR_W = 7;
    localparam int         ARR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [7:0] COUNT = 8'(NUM_REGS);
    localparam logic [6:0] LIMIT = 7'(NUM_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

    smbr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_c), .stop_o(stop_c)
    );

    smbr_state_e      state, pend;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh, tx_byte, cnt_left;
    logic             ack_q, blk_q, need_cnt, cnt_phase;
    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       rx_byte, rd_cur, rd_nxt;
    logic [2:0]       tx_sel;
    logic [7:0]       reg_arr [NUM_REGS];

    smbr_regbank #(
        .NUM_REGS(NUM_REGS), .IDX_W(PTR_W), .ID_IDX(ID_IDX),
        .ID_VALUE(ID_VALUE), .ONES_IDX(ONES_IDX), .ONES_MASK(ONES_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_o(regs_o)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
        assign reg_arr[g] = regs_o[g*8 +: 8];
    end

    // Byte assembly, read data lookup and transmit bit selection.
    always_comb begin
        rx_byte = {rx_sh[6:0], sda_s};
        rd_cur  = (ptr < LIMIT) ? reg_arr[ptr[ARR_W-1:0]] : 8'hFF;
        rd_nxt  = ((ptr + 7'd1) < LIMIT) ? reg_arr[ARR_W'(ptr + 7'd1)] : 8'hFF;
        tx_sel  = 3'(4'd7 - bitcnt);
    end

    // Transfer engine: bit counting, byte decode, ack and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;   pend <= ST_IDLE;
            bitcnt <= '0;       rx_sh <= '0;      tx_byte <= '0;
            cnt_left <= '0;     ack_q <= 1'b0;    blk_q <= 1'b0;
            need_cnt <= 1'b0;   cnt_phase <= 1'b0; ptr <= '0;
            wr_en <= 1'b0;      wr_idx <= '0;     wr_data <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_c) begin
                state <= ST_IDLE; bitcnt <= '0; ack_q <= 1'b0; sda_oe_o <= 1'b0;
            end else if (start_c) begin
                state <= ST_ADDR; bitcnt <= '0; ack_q <= 1'b0; sda_oe_o <= 1'b0;
            end else begin
                if (scl_rise && state != ST_IDLE && state != ST_SKIP) begin
                    if (bitcnt < 4'd8) begin
                        rx_sh  <= rx_byte;
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            ack_q <= 1'b0;
                            pend  <= ST_SKIP;
                            case (state)
                                ST_ADDR: if (rx_byte[7:1] == SLAVE_ADDR) begin
                                    ack_q <= 1'b1;
                                    pend  <= rx_byte[0] ? ST_TX : ST_CMD;
                                end
                                ST_CMD: if (rx_byte[7]) begin
                                    blk_q <= 1'b0; ptr <= rx_byte[6:0];
                                    cnt_left <= 8'd1; need_cnt <= 1'b0;
                                    ack_q <= 1'b1; pend <= ST_WDATA;
                                end else if (rx_byte == BLOCK_CODE) begin
                                    blk_q <= 1'b1; ptr <= '0; need_cnt <= 1'b1;
                                    ack_q <= 1'b1; pend <= ST_WDATA;
                                end
                                ST_WDATA: if (need_cnt) begin
                                    cnt_left <= rx_byte; need_cnt <= 1'b0;
                                    ack_q <= 1'b1; pend <= ST_WDATA;
                                end else if (cnt_left != 8'd0 && ptr < LIMIT) begin
                                    wr_en <= 1'b1; wr_idx <= ptr; wr_data <= rx_byte;
                                    ptr <= ptr + 7'd1; cnt_left <= cnt_left - 8'd1;
                                    ack_q <= 1'b1; pend <= ST_WDATA;
                                end
                                default: pend <= state;
                            endcase
                        end
                    end else begin
                        bitcnt <= '0;
                        if (state == ST_TX) begin
                            if (sda_s) begin
                                state <= ST_SKIP;
                            end else if (cnt_phase) begin
                                cnt_phase <= 1'b0; tx_byte <= rd_cur;
                            end else begin
                                ptr <= ptr + 7'd1; tx_byte <= rd_nxt;
                            end
                        end else begin
                            state <= pend;
                            if (pend == ST_TX) begin
                                cnt_phase <= blk_q;
                                tx_byte   <= blk_q ? COUNT : rd_cur;
                            end
                        end
                    end
                end
                if (scl_fall) begin
                    if (bitcnt == 4'd8)
                        sda_oe_o <= (state != ST_TX) && ack_q;
                    else
                        sda_oe_o <= (state == ST_TX) && !tx_byte[tx_sel];
                end
            end
        end
    end

    // R10
    no_drive_change_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));
    // R8
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (state == ST_IDLE && !sda_oe_o));
    // R1
    quiet_when_unaddressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe_o);
    // R4
    write_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WDATA && wr_idx < LIMIT));
endmodule

// File: tb/smbr_slave_tb.sv
module smbr_slave_tb;
    localparam int         N      = 8;
    localparam logic [6:0] SADDR  = 7'h69;
    localparam int         IDI    = 6;
    localparam logic [7:0] IDV    = 8'h29;
    localparam int         ONI    = 7;
    localparam logic [7:0] ONM    = 8'hC0;
    localparam int         Q      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [N*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] model [N];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;

    smbr_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_write(input int idx, input logic [7:0] d, input logic [7:0] old);
        if (idx == IDI) return old;
        if (idx == ONI) return d | ONM;
        return d;
    endfunction

    function automatic logic [7:0] model_read(input int idx);
        return (idx < N) ? model[idx] : 8'hFF;
    endfunction

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; w(Q); scl_m = 1'b1; w(Q); s = sda_bus; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(output logic [7:0] d, input bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
        clk_bit(!ack, s);
    endtask

    task automatic byte_write(input logic [6:0] a, input logic [6:0] off, input logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        bus_start(); wr_byte({a, 1'b0}, k1);
        if (k1) begin wr_byte({1'b1, off}, k2); wr_byte(d, k3); end
        bus_stop();
        ok = k1 && k2 && k3;
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
        bit k;
        bus_start(); wr_byte({SADDR, 1'b0}, k); wr_byte({1'b1, off}, k);
        bus_start(); wr_byte({SADDR, 1'b1}, k); rd_byte(d, 1'b0);
        bus_stop();
    endtask

    task automatic block_write(input int cnt, input int nsend, output int acks);
        bit k;
        acks = 0;
        bus_start(); wr_byte({SADDR, 1'b0}, k); wr_byte(8'h00, k); wr_byte(8'(cnt), k);
        for (int i = 0; i < nsend; i++) begin wr_byte(wbuf[i], k); if (k) acks++; end
        bus_stop();
    endtask

    task automatic block_read(input int nread, output logic [7:0] cnt);
        bit k;
        bus_start(); wr_byte({SADDR, 1'b0}, k); wr_byte(8'h00, k);
        bus_start(); wr_byte({SADDR, 1'b1}, k); rd_byte(cnt, 1'b1);
        for (int i = 0; i < nread; i++) rd_byte(rbuf[i], i != nread - 1);
        bus_stop();
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < N; i++) check(tag, regs[i*8 +: 8], model[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        int acks;
        logic [7:0] d, c;
        logic [6:0] off;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) model[i] = (i == IDI) ? IDV : (i == ONI) ? ONM : 8'h00;
        w(5); rst_n = 1'b1; w(5);

        // R11 reset contents, SDA released
        check_regs("R11 reset regs");
        check("R11 reset sda_oe", sda_oe, 0);

        // R2 directed byte write, R3 read back
        byte_write(SADDR, 7'd2, 8'hA5, ok); model[2] = 8'hA5;
        check("R2 ack", ok, 1); check_regs("R2 byte write");
        byte_read(7'd2, d); check("R3 byte read", d, 8'hA5);

        // R6 write to ID ignored
        byte_write(SADDR, 7'(IDI), 8'h00, ok);
        check_regs("R6 id write ignored");
        byte_read(7'(IDI), d); check("R6 id read", d, IDV);

        // R7 forced ones
        byte_write(SADDR, 7'(ONI), 8'h05, ok); model[ONI] = 8'hC5;
        check_regs("R7 ones forced");

        // R1 wrong address refused, nothing stored
        byte_write(SADDR ^ 7'h01, 7'd0, 8'h77, ok);
        check("R1 foreign address nack", ok, 0); check_regs("R1 no change");

        // R9 unsupported command refused
        bus_start(); wr_byte({SADDR, 1'b0}, ok); wr_byte(8'h05, ok); bus_stop();
        check("R9 command nack", ok, 0);

        // R2 extra data byte refused
        bus_start(); wr_byte({SADDR, 1'b0}, ok); wr_byte(8'h81, ok); wr_byte(8'h11, ok);
        wr_byte(8'h22, ok); bus_stop(); model[1] = 8'h11;
        check("R2 second data nack", ok, 0); check_regs("R2 single store");

        // R3 out-of-range offset reads FF
        byte_read(7'd40, d); check("R3 out of range", d, 8'hFF);

        // R4 full block write (ID ignored, ones forced)
        for (int i = 0; i < N; i++) begin
            wbuf[i] = 8'($urandom); model[i] = model_write(i, wbuf[i], model[i]);
        end
        block_write(N, N, acks); check("R4 block acks", acks, N); check_regs("R4 block write");

        // R4 data beyond count refused
        wbuf[0] = 8'h3C; wbuf[1] = 8'h4D; wbuf[2] = 8'h5E;
        block_write(2, 3, acks); model[0] = 8'h3C; model[1] = 8'h4D;
        check("R4 beyond count acks", acks, 2); check_regs("R4 beyond count");

        // R5 block read: count then data
        block_read(N, c); check("R5 count", c, N);
        for (int i = 0; i < N; i++) check("R5 block data", rbuf[i], model[i]);
        block_read(3, c);
        for (int i = 0; i < 3; i++) check("R5 short block data", rbuf[i], model[i]);

        // R8 stop in the middle of a data byte
        bus_start(); wr_byte({SADDR, 1'b0}, ok); wr_byte(8'h00, ok); wr_byte(8'd3, ok);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, ok);
        bus_stop();
        check("R8 released after stop", sda_oe, 0); check_regs("R8 no partial store");
        byte_read(7'd0, d); check("R8 usable after stop", d, model[0]);

        // R2/R3 random byte accesses
        for (int it = 0; it < 30; it++) begin
            off = 7'($urandom % (N + 1)); d = 8'($urandom);
            byte_write(SADDR, off, d, ok);
            if (off < N) model[off] = model_write(int'(off), d, model[off]);
            check("R2 random ack", ok, off < N);
            check_regs("R2 random store");
            byte_read(off, c); check("R3 random read", c, model_read(int'(off)));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule